// File: doc/BRIEF.md
# Phase-Error PID Loop Filter with Oscillator Steering

This block closes the loop of a digital phase-locked FM demodulator. Each time the phase detector presents a new signed phase-error sample with its strobe, the block forms a proportional, an integral and a derivative term from that sample using fixed-point gains with seven fraction bits. It adds the three terms and clamps the sum to a signed correction value.

The correction has two uses. It leaves the block as the demodulated data. The same value, sign-extended, is added to a fixed 26-bit centre-frequency word to give the increment word for the local numerically controlled oscillator. Both outputs are registered. They change one clock after an accepted sample and hold their values between samples.

Top module: `dpll_loop_filter`

## Requirements
- R1: While reset is asserted and right after it, the correction is 0 and the frequency word equals the centre word 0x0080000 (only bit 19 set). The integrator and the stored previous error both start at 0.
- R2: A cycle with the strobe low changes neither output, whatever the error input carries.
- R3: For an accepted sample e, the proportional term is floor(e*2/128) and the correction is the sum of the proportional, integral and derivative terms. All shifts by 7 are arithmetic, so they round toward minus infinity.
- R4: Each accepted sample adds e*1 to a signed integrator. The integral term is floor(integrator/128) and uses the integrator value that already includes the current sample.
- R5: The derivative term is floor((e - e_prev)*2/128). Here e_prev is the last accepted sample, and it is 0 after reset.
- R6: The integrator is 24 bits wide. It saturates at +8388607 and -8388608 instead of wrapping, and it recovers from saturation at once when the error changes sign.
- R7: The correction is a 16-bit signed value. A term sum above +32767 or below -32768 is clamped to that limit.
- R8: The frequency word equals the centre word plus the sign-extended correction, taken modulo 2^26.
- R9: Both outputs keep their old values until the first rising clock edge at which the strobe is high. They show the new values just after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_vld | input | 1 | Strobe marking err_in as a new sample |
| err_in | input | 16 | Signed phase error from the detector |
| corr_out | output | 16 | Signed loop correction, also the demodulated data |
| freq_word | output | 26 | Oscillator increment word: centre word plus correction |

## Verification
A bad integrator value does not stay hidden. It appears in the correction on the next accepted sample, and it is most visible when the bench holds the error at one extreme for hundreds of samples and then reverses it. A wrapped or stuck integrator then leaves the clamp at a different sample, or never, and the recovery sample shows the mismatch. A stale previous-error register moves the correction by the derivative term on the very next strobe. Centre-word or sign-extension faults show on freq_word in the first cycle after reset, and again whenever the correction goes negative.

// File: rtl/dpll_lf_pkg.sv
package dpll_lf_pkg;

   localparam int unsigned DEF_ERR_W  = 16;
   localparam int unsigned DEF_GAIN_W = 16;
   localparam int unsigned DEF_FRAC   = 7;
   localparam int unsigned DEF_KP     = 2;
   localparam int unsigned DEF_KI     = 1;
   localparam int unsigned DEF_KD     = 2;
   localparam int unsigned DEF_ACC_W  = 24;
   localparam int unsigned DEF_CORR_W = 16;
   localparam int unsigned DEF_FW_W   = 26;
   localparam logic [DEF_FW_W-1:0] DEF_CENTRE = 26'h0080000;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      return max2(max2(a, b), c);
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pid_sat.sv
module pid_sat #(
   parameter int unsigned IN_W  = 20,
   parameter int unsigned OUT_W = 16
) (
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout,
   output logic                    clip_hi,
   output logic                    clip_lo
);
   localparam int unsigned PAD = IN_W - OUT_W + 1;
   localparam logic signed [IN_W-1:0] HI = {{PAD{1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [IN_W-1:0] LO = {{PAD{1'b1}}, {(OUT_W-1){1'b0}}};

   if (IN_W <= OUT_W) begin : g_bad_width
      $error("pid_sat: IN_W must exceed OUT_W");
   end

   always_comb begin
      clip_hi = (din > HI);
      clip_lo = (din < LO);
      if (clip_hi)      dout = HI[OUT_W-1:0];
      else if (clip_lo) dout = LO[OUT_W-1:0];
      else              dout = din[OUT_W-1:0];
   end
endmodule

// File: rtl/pid_gain_term.sv
module pid_gain_term
   import dpll_lf_pkg::*;
#(
   parameter int unsigned IN_W   = 16,
   parameter int unsigned GAIN_W = 16,
   parameter int unsigned GAIN   = 2,
   parameter int unsigned FRAC   = 7,
   parameter int unsigned OUT_W  = IN_W + GAIN_W + 1
) (
   input  logic signed [IN_W-1:0]  x,
   output logic signed [OUT_W-1:0] y
);
   localparam int unsigned PW = IN_W + GAIN_W + 1;

   if (OUT_W != PW) begin : g_bad_out
      $error("pid_gain_term: OUT_W must equal IN_W+GAIN_W+1");
   end
   if (GAIN >= (1 << GAIN_W)) begin : g_bad_gain
      $error("pid_gain_term: GAIN does not fit GAIN_W");
   end
   if (FRAC >= PW) begin : g_bad_frac
      $error("pid_gain_term: FRAC too large");
   end

   logic signed [PW-1:0] x_ext;
   logic signed [PW-1:0] prod;

   assign x_ext = PW'(x);

   if (is_pow2(GAIN)) begin : g_shift
      localparam int unsigned SH = $clog2(GAIN);
      assign prod = x_ext <<< SH;
   end else begin : g_mult
      localparam logic signed [PW-1:0] G = PW'(GAIN);
      assign prod = x_ext * G;
   end

   assign y = prod >>> FRAC;
endmodule

// File: rtl/pid_integrator.sv
module pid_integrator
   import dpll_lf_pkg::*;
#(
   parameter int unsigned INC_W = 33,
   parameter int unsigned ACC_W = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic signed [INC_W-1:0] inc,
   output logic signed [ACC_W-1:0] acc_next,
   output logic signed [ACC_W-1:0] acc_q
);
   localparam int unsigned SW = max2(INC_W, ACC_W) + 1;
   localparam logic signed [ACC_W-1:0] ACC_HI = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] ACC_LO = {1'b1, {(ACC_W-1){1'b0}}};

   if (ACC_W < 4) begin : g_bad_acc
      $error("pid_integrator: ACC_W too small");
   end

   logic signed [SW-1:0]    sum_w;
   logic signed [ACC_W-1:0] sum_sat;
   logic                    hi_unused;
   logic                    lo_unused;

   assign sum_w = SW'(acc_q) + SW'(inc);

   pid_sat #(.IN_W(SW), .OUT_W(ACC_W)) u_clamp (
      .din     (sum_w),
      .dout    (sum_sat),
      .clip_hi (hi_unused),
      .clip_lo (lo_unused)
   );

   assign acc_next = en ? sum_sat : acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_next;
   end

   // R6: a full integrator fed a non-negative step stays at the upper limit
   a_r6_sat_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (en && acc_q == ACC_HI && inc >= 0) |=> (acc_q == ACC_HI));
   // R6: an empty integrator fed a non-positive step stays at the lower limit
   a_r6_sat_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (en && acc_q == ACC_LO && inc <= 0) |=> (acc_q == ACC_LO));
   // R2: no strobe, no integrator change
   a_r2_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(acc_q));
endmodule

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter
   import dpll_lf_pkg::*;
#(
   parameter int unsigned ERR_W  = DEF_ERR_W,
   parameter int unsigned GAIN_W = DEF_GAIN_W,
   parameter int unsigned FRAC   = DEF_FRAC,
   parameter int unsigned KP     = DEF_KP,
   parameter int unsigned KI     = DEF_KI,
   parameter int unsigned KD     = DEF_KD,
   parameter int unsigned ACC_W  = DEF_ACC_W,
   parameter int unsigned CORR_W = DEF_CORR_W,
   parameter int unsigned FW_W   = DEF_FW_W,
   parameter logic [FW_W-1:0] CENTRE = DEF_CENTRE
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     err_vld,
   input  logic signed [ERR_W-1:0]  err_in,
   output logic signed [CORR_W-1:0] corr_out,
   output logic [FW_W-1:0]          freq_word
);
   localparam int unsigned P_W  = ERR_W + GAIN_W + 1;
   localparam int unsigned DF_W = ERR_W + 1;
   localparam int unsigned D_W  = DF_W + GAIN_W + 1;
   localparam int unsigned S_W  = max3(P_W, ACC_W, D_W) + 2;

   if (CORR_W > FW_W) begin : g_bad_corr
      $error("dpll_loop_filter: CORR_W must not exceed FW_W");
   end
   if (FRAC >= ACC_W) begin : g_bad_frac
      $error("dpll_loop_filter: FRAC must be below ACC_W");
   end

   logic signed [ERR_W-1:0]  prev_q;
   logic signed [DF_W-1:0]   diff;
   logic signed [P_W-1:0]    p_term;
   logic signed [P_W-1:0]    i_inc;
   logic signed [D_W-1:0]    d_term;
   logic signed [ACC_W-1:0]  acc_next;
   logic signed [ACC_W-1:0]  acc_q;
   logic signed [ACC_W-1:0]  i_term;
   logic signed [S_W-1:0]    sum_w;
   logic signed [CORR_W-1:0] corr_next;
   logic                     sum_hi;
   logic                     sum_lo;
   logic [FW_W-1:0]          fw_next;

   pid_gain_term #(.IN_W(ERR_W), .GAIN_W(GAIN_W), .GAIN(KP), .FRAC(FRAC)) u_prop (
      .x (err_in),
      .y (p_term)
   );

   pid_gain_term #(.IN_W(ERR_W), .GAIN_W(GAIN_W), .GAIN(KI), .FRAC(0)) u_intg_gain (
      .x (err_in),
      .y (i_inc)
   );

   pid_integrator #(.INC_W(P_W), .ACC_W(ACC_W)) u_intg (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (err_vld),
      .inc      (i_inc),
      .acc_next (acc_next),
      .acc_q    (acc_q)
   );

   assign i_term = acc_next >>> FRAC;
   assign diff   = DF_W'(err_in) - DF_W'(prev_q);

   pid_gain_term #(.IN_W(DF_W), .GAIN_W(GAIN_W), .GAIN(KD), .FRAC(FRAC)) u_deriv (
      .x (diff),
      .y (d_term)
   );

   assign sum_w = S_W'(p_term) + S_W'(i_term) + S_W'(d_term);

   pid_sat #(.IN_W(S_W), .OUT_W(CORR_W)) u_corr_sat (
      .din     (sum_w),
      .dout    (corr_next),
      .clip_hi (sum_hi),
      .clip_lo (sum_lo)
   );

   assign fw_next = CENTRE + FW_W'(corr_next);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= '0;
         corr_out  <= '0;
         freq_word <= CENTRE;
      end else if (err_vld) begin
         prev_q    <= err_in;
         corr_out  <= corr_next;
         freq_word <= fw_next;
      end
   end

   // R2 / R9: without a strobe both outputs and the stored error hold
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !err_vld |=> ($stable(corr_out) && $stable(freq_word) && $stable(prev_q)));
   // R5: the stored error follows the last accepted sample
   a_r5_prev: assert property (@(posedge clk) disable iff (!rst_n)
      err_vld |=> (prev_q == $past(err_in)));
   // R7: an over-range sum lands on the positive limit
   a_r7_clip_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (err_vld && sum_hi) |=> (corr_out == {1'b0, {(CORR_W-1){1'b1}}}));
   // R7: an under-range sum lands on the negative limit
   a_r7_clip_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (err_vld && sum_lo) |=> (corr_out == {1'b1, {(CORR_W-1){1'b0}}}));
   // R8: oscillator word stays locked to the correction around the centre
   a_r8_word: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (freq_word == FW_W'(CENTRE + FW_W'(corr_out))));
endmodule

// File: tb/tb_dpll_loop_filter.sv
module tb_dpll_loop_filter;
   localparam int CLK_P = 10;
   localparam longint CENTRE = 64'h80000;
   localparam longint FW_MASK = (64'sd1 <<< 26) - 1;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               err_vld = 1'b0;
   logic signed [15:0] err_in = '0;
   logic signed [15:0] corr_out;
   logic [25:0]        freq_word;

   int total = 0;
   int fails = 0;

   longint m_acc = 0;
   longint m_prev = 0;
   longint m_corr = 0;

   always #(CLK_P/2) clk = ~clk;

   dpll_loop_filter dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .err_vld   (err_vld),
      .err_in    (err_in),
      .corr_out  (corr_out),
      .freq_word (freq_word)
   );

   function automatic longint clamp(input longint v, input longint lo, input longint hi);
      return (v > hi) ? hi : ((v < lo) ? lo : v);
   endfunction

   function automatic longint exp_word(input longint c);
      return (CENTRE + c) & FW_MASK;
   endfunction

   task automatic model_step(input longint e);
      longint p, i, d;
      p      = (e * 2) >>> 7;
      m_acc  = clamp(m_acc + e * 1, -(64'sd1 <<< 23), (64'sd1 <<< 23) - 1);
      i      = m_acc >>> 7;
      d      = ((e - m_prev) * 2) >>> 7;
      m_prev = e;
      m_corr = clamp(p + i + d, -32768, 32767);
   endtask

   task automatic check(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input bit v, input longint e, input string req);
      longint old_c, old_f;
      @(negedge clk);
      old_c   = longint'(corr_out);
      old_f   = longint'(freq_word);
      err_vld = v;
      err_in  = 16'(e);
      #1;
      check("R9 no early change", longint'(corr_out), old_c);
      @(negedge clk);
      if (v) model_step(e);
      check(req, longint'(corr_out), m_corr);
      check({req, " R8 word"}, longint'(freq_word), exp_word(m_corr));
      err_vld = 1'b0;
   endtask

   initial begin
      #(CLK_P * 200000);
      total++;
      fails++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int unsigned seed_sink;
      seed_sink = $urandom(32'd5150);
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 corr in reset", longint'(corr_out), 0);
      check("R1 word in reset", longint'(freq_word), CENTRE);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 corr after reset", longint'(corr_out), 0);
      check("R1 word after reset", longint'(freq_word), CENTRE);

      // R3 / R5: first sample, previous error is zero -> 15 + 7 + 15
      step(1'b1, 1000, "R3 first sample");
      check("R5 first sample total", m_corr, 37);
      // R2: strobe low with a wild error leaves outputs alone
      step(1'b0, -32768, "R2 hold");
      step(1'b0, 12345, "R2 hold again");
      // R5: same error again -> derivative zero, integrator doubles
      step(1'b1, 1000, "R5 repeated error");
      // R3: negative values round toward minus infinity
      step(1'b1, -1, "R3 floor of negative");
      step(1'b1, -200, "R3 negative sample");
      step(1'b1, 0, "R5 return to zero");
      // R4: constant error ramps the integral term
      for (int k = 0; k < 20; k++) step(1'b1, 640, "R4 ramp");
      // R6 / R7: drive integrator to its upper limit and past it
      for (int k = 0; k < 300; k++) step(1'b1, 32767, "R6 push high");
      check("R7 clipped high", longint'(corr_out), 32767);
      for (int k = 0; k < 600; k++) step(1'b1, -32768, "R6 push low");
      check("R7 clipped low", longint'(corr_out), -32768);
      check("R8 low word", longint'(freq_word), exp_word(-32768));
      for (int k = 0; k < 40; k++) step(1'b1, 32000, "R6 recover");
      // mixed random, including idle cycles
      for (int k = 0; k < 400; k++) begin
         bit v;
         longint e;
         v = ($urandom % 4) != 0;
         e = longint'($signed(16'($urandom)));
         if (($urandom % 8) == 0) e = ($urandom % 2) ? 32767 : -32768;
         step(v, e, v ? "R3 random" : "R2 random idle");
      end
      // R1: reset again mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 async reset corr", longint'(corr_out), 0);
      check("R1 async reset word", longint'(freq_word), CENTRE);
      @(negedge clk);
      rst_n = 1'b1;
      m_acc = 0; m_prev = 0; m_corr = 0;
      step(1'b1, -5000, "R5 prev cleared by reset");

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule